// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block is the digital controller that decides when a two-wire bus repeater may tie its local segment to a live backplane segment. It watches a supply-good flag, an enable input and the sampled levels of the clock and data lines on both sides. From these it drives four outputs: a precharge request for the pad bias sources, a connect signal for the pass path, a permit for the rising-edge accelerators, and a pull-down request for an open-drain ready pin.

After power and enable are both present, the controller waits a settle delay. It then precharges and looks for a safe moment to join. That moment is either a stretch of idle bus, with both input-side lines high for a full timed window, or a STOP condition on the input side. In both cases both far-side lines must be high. Once joined, the controller stays joined until enable or power goes away. Both delays are counted in system clocks. By default they are derived from the clock frequency and from the microsecond targets: 86 us to settle and 83 us of idle. The idle target can be set anywhere in the 50 us to 150 us range. All inputs are taken as already synchronized.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `supply_ok` is 0, `link_on`, `accel_ok` and `precharge_en` are 0 and `ready_sink` is 1, whatever the bus lines do.
- R2: `bus_enable` at 0 forces `link_on`, `accel_ok` and `precharge_en` to 0 in the same cycle, from any state. It also sends the controller back to the start, so a later enable must run the full settle delay again.
- R3: With `supply_ok` and `bus_enable` both 1 and no connection made, `precharge_en` is 1.
- R4: After enable is seen at a rising edge, the bus is ignored for SETTLE_CYCLES+1 further edges. Connection conditions are looked for only from the edge after that.
- R5: In the seek phase, `link_on` goes to 1 at the edge after the IDLE_CYCLES-th consecutive edge at which `in_scl` and `in_sda` were both 1, provided `out_scl` and `out_sda` are 1.
- R6: A 0 on `in_scl` or `in_sda` at any edge during the idle count restarts the count from zero.
- R7: A STOP connects at the very edge it is sampled, provided both output-side lines are 1. A STOP is `in_sda` sampled 0 then 1 on consecutive edges, with `in_scl` sampled 1 at both of those edges.
- R8: Neither a STOP nor a finished idle window connects while `out_scl` or `out_sda` is 0. If the input-side lines stay high, the idle path connects once the output-side lines are high.
- R9: A change in which `in_scl` and `in_sda` both go from 0 to 1 at the same edge is not a STOP.
- R10: `ready_sink` is 1 (pin pulled low) unless the controller is connected with enable and supply present, in which case it is 0.
- R11: When the connection is made, `precharge_en` falls and `accel_ok` rises in the same cycle that `link_on` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Debounced supply-good flag |
| bus_enable | input | 1 | Enable request; 0 isolates the two sides |
| in_scl | input | 1 | Sampled input-side clock line |
| in_sda | input | 1 | Sampled input-side data line |
| out_scl | input | 1 | Sampled output-side clock line |
| out_sda | input | 1 | Sampled output-side data line |
| precharge_en | output | 1 | Request to bias the pads before connection |
| link_on | output | 1 | Connect the two sides of the repeater |
| accel_ok | output | 1 | Permit the rising-edge accelerators |
| ready_sink | output | 1 | 1 = pull the open-drain ready pin low |

## Verification
The bench goes after the exact cycle of connection after a fresh enable. A settle or idle counter off by one would move `link_on` by an edge, and the bench samples both sides of the expected edge. It drops one input line low late in the idle window: a design that does not restart the count connects about an idle window too early. It also applies a table of line transitions to the STOP detector. In that table, a simultaneous rise of clock and data would connect a design that compares only current levels. A STOP while a far-side line is low would connect a design that ignores the output side. The bench also pulses STOPs during the settle phase and while unpowered, where a controller that watched the bus too early would join a live bus mid-transfer.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    typedef enum logic [1:0] {
        LNK_OFF    = 2'd0,
        LNK_SETTLE = 2'd1,
        LNK_SEEK   = 2'd2,
        LNK_ON     = 2'd3
    } lnk_state_e;

    typedef struct packed {
        lnk_state_e state;
    } ctrl_regs_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

endpackage

// File: rtl/hsl_delay_count.sv
module hsl_delay_count #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == TOP);
endmodule

// File: rtl/hsl_stop_detect.sv
module hsl_stop_detect
    import hsl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic stop_seen
);
    line_pair_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl;
        prev_d.sda = sda;
        // Data rising while clock held high in both samples.
        stop_seen = prev_q.scl && scl && !prev_q.sda && sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl
    import hsl_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 50,
    parameter int unsigned IDLE_US       = 83,
    parameter int unsigned SETTLE_US     = 86,
    parameter int unsigned IDLE_CYCLES   = CLK_MHZ * IDLE_US,
    parameter int unsigned SETTLE_CYCLES = CLK_MHZ * SETTLE_US
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic bus_enable,
    input  logic in_scl,
    input  logic in_sda,
    input  logic out_scl,
    input  logic out_sda,
    output logic precharge_en,
    output logic link_on,
    output logic accel_ok,
    output logic ready_sink
);
    ctrl_regs_t regs_d, regs_q;

    logic live;
    logic settle_clr, settle_done;
    logic idle_clr, idle_done;
    logic stop_seen;
    logic far_high;

    assign live     = supply_ok && bus_enable;
    assign far_high = out_scl && out_sda;

    assign settle_clr = (regs_q.state != LNK_SETTLE);
    assign idle_clr   = (regs_q.state != LNK_SEEK) || !(in_scl && in_sda);

    hsl_delay_count #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (settle_clr),
        .done  (settle_done)
    );

    hsl_delay_count #(.LIMIT(IDLE_CYCLES)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_clr),
        .done  (idle_done)
    );

    hsl_stop_detect u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (in_scl),
        .sda       (in_sda),
        .stop_seen (stop_seen)
    );

    always_comb begin
        regs_d = regs_q;
        if (!live) begin
            regs_d.state = LNK_OFF;
        end else begin
            unique case (regs_q.state)
                LNK_OFF:    regs_d.state = LNK_SETTLE;
                LNK_SETTLE: if (settle_done) regs_d.state = LNK_SEEK;
                LNK_SEEK:   if (far_high && (idle_done || stop_seen)) regs_d.state = LNK_ON;
                LNK_ON:     regs_d.state = LNK_ON;
                default:    regs_d.state = LNK_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: LNK_OFF};
        else        regs_q <= regs_d;
    end

    always_comb begin
        precharge_en = live && ((regs_q.state == LNK_SETTLE) || (regs_q.state == LNK_SEEK));
        link_on      = live && (regs_q.state == LNK_ON);
        accel_ok     = link_on;
        ready_sink   = !link_on;
    end
endmodule

// File: rtl/hsl_checker.sv
module hsl_checker (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic bus_enable,
    input logic out_scl,
    input logic out_sda,
    input logic precharge_en,
    input logic link_on,
    input logic accel_ok,
    input logic ready_sink
);
    a_r1_unpowered_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (!link_on && !precharge_en && !accel_ok && ready_sink));

    a_r2_disable_stays_down: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_enable |=> !link_on);

    a_r3_no_precharge_when_linked: assert property (@(posedge clk) disable iff (!rst_n)
        link_on |-> !precharge_en);

    a_r4_no_instant_link: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(precharge_en) |=> !link_on);

    a_r8_far_side_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> $past(out_scl && out_sda));

    a_r11_handover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> (accel_ok && $past(precharge_en)));

    a_r10_ready_released_only_linked: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_sink |-> (link_on && bus_enable));
endmodule

bind hotswap_link_ctrl hsl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .bus_enable   (bus_enable),
    .out_scl      (out_scl),
    .out_sda      (out_sda),
    .precharge_en (precharge_en),
    .link_on      (link_on),
    .accel_ok     (accel_ok),
    .ready_sink   (ready_sink)
);

// File: tb/sim_hotswap_link_ctrl.sv
module sim_hotswap_link_ctrl;
    localparam int S = 10;
    localparam int I = 16;
    localparam logic [3:0] O_OFF  = 4'b0001;
    localparam logic [3:0] O_PRE  = 4'b1001;
    localparam logic [3:0] O_LINK = 4'b0110;

    // {prev scl, prev sda, cur scl, cur sda, out scl, out sda, expect link}
    localparam logic [6:0] VEC [8] = '{
        7'b10_11_11_1,
        7'b10_11_01_0,
        7'b10_11_10_0,
        7'b00_11_11_0,
        7'b11_10_11_0,
        7'b00_01_11_0,
        7'b10_01_11_0,
        7'b11_11_11_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, bus_enable = 1'b0;
    logic in_scl = 1'b1, in_sda = 1'b1, out_scl = 1'b1, out_sda = 1'b1;
    logic precharge_en, link_on, accel_ok, ready_sink;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hotswap_link_ctrl #(.IDLE_CYCLES(I), .SETTLE_CYCLES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bus_enable(bus_enable),
        .in_scl(in_scl), .in_sda(in_sda), .out_scl(out_scl), .out_sda(out_sda),
        .precharge_en(precharge_en), .link_on(link_on), .accel_ok(accel_ok),
        .ready_sink(ready_sink)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {precharge_en, link_on, accel_ok, ready_sink};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs {pre,link,acc,sink} = %b, expected %b", req, act, exp);
        end
    endtask

    // Fresh enable with input lines low; ends in the seek phase.
    task automatic power_up(input logic o_scl, input logic o_sda);
        bus_enable = 1'b0;
        supply_ok = 1'b1;
        in_scl = 1'b0; in_sda = 1'b0;
        out_scl = o_scl; out_sda = o_sda;
        step(1);
        bus_enable = 1'b1;
        step(S + 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1 reset", O_OFF);
        step(2);
        rst_n = 1'b1;
        bus_enable = 1'b1;
        step(2);
        // R1: STOP and idle bus while unpowered
        in_sda = 1'b0; step(1); in_sda = 1'b1; step(I + 4);
        check("R1 unpowered ignores bus", O_OFF);

        // R4 R5 R11 R10: exact connection cycle with everything high
        supply_ok = 1'b1; bus_enable = 1'b0; step(1);
        bus_enable = 1'b1;
        step(1);
        check("R3 precharge in settle", O_PRE);
        step(S + 1 + I);
        check("R5 one edge before idle window ends", O_PRE);
        step(1);
        check("R11 R10 connect at idle window end", O_LINK);

        // R2: disable drops everything at once
        bus_enable = 1'b0; #1;
        check("R2 disable immediate", O_OFF);
        step(1);
        // R2 R4: re-enable, STOP inside settle must not connect
        bus_enable = 1'b1;
        in_sda = 1'b0; step(1);
        in_sda = 1'b1; step(1);
        check("R4 STOP during settle ignored", O_PRE);

        // Table of STOP detector patterns (R7 R8 R9)
        for (int k = 0; k < 8; k++) begin
            power_up(VEC[k][2], VEC[k][1]);
            in_scl = VEC[k][6]; in_sda = VEC[k][5]; step(1);
            in_scl = VEC[k][4]; in_sda = VEC[k][3]; step(1);
            if (VEC[k][0]) check($sformatf("R7 vector %0d", k), O_LINK);
            else           check($sformatf("R8 R9 vector %0d", k), O_PRE);
        end

        // R6 R9: idle restart
        power_up(1'b1, 1'b1);
        in_scl = 1'b1; in_sda = 1'b1; step(1);
        check("R9 simultaneous rise is not STOP", O_PRE);
        step(I - 2);
        in_scl = 1'b0; step(1);
        in_scl = 1'b1; step(I);
        check("R6 count restarted", O_PRE);
        step(1);
        check("R6 connect after full window", O_LINK);

        // R8: STOP with far side low, then idle once far side high
        power_up(1'b1, 1'b0);
        in_scl = 1'b1; in_sda = 1'b0; step(1);
        in_sda = 1'b1; step(1);
        check("R8 STOP blocked by far side low", O_PRE);
        step(I + 2);
        check("R8 idle waits for far side", O_PRE);
        out_sda = 1'b1; step(1);
        check("R8 idle connect after far side high", O_LINK);

        // R1: supply loss while connected
        supply_ok = 1'b0; #1;
        check("R1 supply loss immediate", O_OFF);
        step(1);
        supply_ok = 1'b1; step(1);
        check("R1 R3 restart after supply returns", O_PRE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule